// File: doc/BRIEF.md
# PFD Lock Monitor

This block decides whether a phase-locked loop has settled. It watches the up and down pulses of a phase-frequency detector and measures the phase error of every comparison cycle. The measurement counts the periods of a fast sampling clock during which exactly one of the two pulses is high. A comparison cycle is delimited by rising edges of a reference-cycle marker. When the error of a closed cycle is below a programmable count, that cycle is "good". After a fixed run of consecutive good cycles, an active-high lock flag is raised.

One bad cycle clears the run and drops the flag on the same clock edge. The count limit comes from an input. When that input is zero, a built-in default is used, derived from a 3 ns window at the sampling period. The lock flag is also one of four sources of a multiplexed status output. That output has its own output-enable, so it can be driven high, driven low, carry the lock flag or release the pin.

All inputs are synchronous to the fast clock. Any synchronisation of the detector pulses happens before this block.

Top module: `pfd_lock_monitor`

## Requirements
- R1: The error of a cycle is the number of fast-clock edges at which `pfd_up` XOR `pfd_dn` is sampled high. Samples with both pulses high, or both low, add nothing.
- R2: A cycle closes at the clock edge where `ref_mark` is sampled high after being sampled low. The error accumulator restarts there, so each cycle's error excludes earlier cycles.
- R3: The first marker edge after reset only opens a measurement. It is not evaluated, so lock needs RUN_LEN+1 marker edges after reset.
- R4: A closed cycle is good when its error is strictly below the limit. The limit is `err_limit`, or DEF_LIMIT when `err_limit` is 0. DEF_LIMIT is 3 with the default 1000 ps sample period and 3000 ps window.
- R5: `lock` goes high at the closing edge of the 40th (RUN_LEN) consecutive good cycle, and not earlier.
- R6: A bad cycle clears the run counter and drives `lock` low at its closing edge.
- R7: The run counter saturates at RUN_LEN, so `lock` stays high through any number of further good cycles.
- R8: The error accumulator saturates at all ones and never wraps. A long error pulse is therefore never judged small.
- R9: `stat_sel` chooses the status output. 2'b00 gives `stat_out`=`lock` with `stat_oe`=1. 2'b01 gives a constant 1 with `stat_oe`=1. 2'b10 gives a constant 0 with `stat_oe`=1. 2'b11 gives high impedance, with `stat_oe`=0 and `stat_out`=0.
- R10: A synchronous reset (`rst` high at a clock edge) clears both counters, the marker history and `lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| pfd_up | input | 1 | Detector up pulse |
| pfd_dn | input | 1 | Detector down pulse |
| ref_mark | input | 1 | Reference-cycle marker; rising edge closes a cycle |
| err_limit | input | ERR_W | Error limit in clock periods; 0 selects DEF_LIMIT |
| stat_sel | input | 2 | Status output source select |
| lock | output | 1 | Lock flag, active high |
| stat_out | output | 1 | Status output data |
| stat_oe | output | 1 | Status output drive enable |

## Verification
The error measurement is tried with three pulse patterns:
- up-only pulses;
- down-only pulses;
- overlapping up-and-down pulses.

The first two show that either polarity counts. The overlap separates an XOR count from an OR count. Errors are placed one below, at and above the default limit and two programmed limits, which pins down the strict comparison and the zero-means-default rule. Runs of 39 versus 40 good cycles, a reset in the middle of a lock, and the extra edge needed right after reset tell an off-by-one run or a missing arming step from the intended count. A 300-period pulse against a limit of 255 shows whether the accumulator wraps.

// File: rtl/lockmon_pkg.sv
package lockmon_pkg;

  typedef enum logic [1:0] {
    SEL_LOCK = 2'b00,
    SEL_HIGH = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_HIZ  = 2'b11
  } stat_sel_e;

  // number of whole sample periods that fit into a time window
  function automatic int window_count(input int window_ps, input int sample_ps);
    int n;
    n = window_ps / sample_ps;
    if (n < 1) n = 1;
    return n;
  endfunction

endpackage

// File: rtl/lockmon_err_meter.sv
module lockmon_err_meter #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pfd_up,
  input  logic             pfd_dn,
  input  logic             ref_mark,
  output logic             cycle_end,
  output logic [ERR_W-1:0] cycle_err
);

  localparam logic [ERR_W-1:0] ACC_MAX = {ERR_W{1'b1}};

  // saturating increment by one sample
  function automatic logic [ERR_W-1:0] sat_step(input logic [ERR_W-1:0] v,
                                                input logic inc);
    if (!inc || v == ACC_MAX) return v;
    return v + ERR_W'(1);
  endfunction

  logic             ref_q;
  logic             armed;
  logic [ERR_W-1:0] acc;
  logic             one_side;
  logic             mark_rise;

  assign one_side  = pfd_up ^ pfd_dn;
  assign mark_rise = ref_mark & ~ref_q;
  assign cycle_end = mark_rise & armed;
  assign cycle_err = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      armed <= 1'b0;
      acc   <= '0;
    end else begin
      ref_q <= ref_mark;
      if (mark_rise) begin
        armed <= 1'b1;
        acc   <= ERR_W'(one_side);
      end else begin
        acc   <= sat_step(acc, one_side);
      end
    end
  end

  AST_ACC_RESTART: assert property (@(posedge clk) disable iff (rst)
    mark_rise |=> (acc <= ERR_W'(1)));                                    // R2
  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!mark_rise && acc == ACC_MAX) |=> (acc == ACC_MAX));                 // R8
  AST_ACC_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!mark_rise && !one_side) |=> $stable(acc));                          // R1
  AST_ARMED_STAYS: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed);                                                     // R3

endmodule

// File: rtl/lockmon_run_track.sv
module lockmon_run_track #(
  parameter int ERR_W     = 8,
  parameter int RUN_LEN   = 40,
  parameter int DEF_LIMIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cycle_end,
  input  logic [ERR_W-1:0] cycle_err,
  input  logic [ERR_W-1:0] err_limit,
  output logic             lock
);

  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_TOP  = RUN_W'(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(RUN_LEN - 1);
  localparam logic [ERR_W-1:0] DEF_LIM  = ERR_W'(DEF_LIMIT);

  // zero on the limit input selects the built-in default
  function automatic logic [ERR_W-1:0] pick_limit(input logic [ERR_W-1:0] cfg);
    return (cfg == '0) ? DEF_LIM : cfg;
  endfunction

  function automatic logic [RUN_W-1:0] run_next(input logic [RUN_W-1:0] r);
    return (r >= RUN_TOP) ? RUN_TOP : r + RUN_W'(1);
  endfunction

  logic [ERR_W-1:0] limit_eff;
  logic             good_cycle;
  logic             bad_cycle;
  logic [RUN_W-1:0] run_cnt;

  assign limit_eff  = pick_limit(err_limit);
  assign good_cycle = cycle_end && (cycle_err < limit_eff);
  assign bad_cycle  = cycle_end && !(cycle_err < limit_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
      lock    <= 1'b0;
    end else if (good_cycle) begin
      run_cnt <= run_next(run_cnt);
      lock    <= (run_cnt >= RUN_LAST);
    end else if (bad_cycle) begin
      run_cnt <= '0;
      lock    <= 1'b0;
    end
  end

  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= RUN_TOP);                                                  // R7
  AST_LOCK_HAS_RUN: assert property (@(posedge clk) disable iff (rst)
    lock |-> (run_cnt == RUN_TOP));                                       // R5
  AST_BAD_DROPS: assert property (@(posedge clk) disable iff (rst)
    bad_cycle |=> (!lock && run_cnt == '0));                              // R6
  AST_LOCK_KEPT: assert property (@(posedge clk) disable iff (rst)
    (lock && !bad_cycle) |=> lock);                                       // R7

endmodule

// File: rtl/lockmon_status_mux.sv
module lockmon_status_mux
  import lockmon_pkg::*;
(
  input  logic      lock,
  input  stat_sel_e sel,
  output logic      stat_out,
  output logic      stat_oe
);

  always_comb begin
    stat_out = 1'b0;
    stat_oe  = 1'b1;
    unique case (sel)
      SEL_LOCK: stat_out = lock;
      SEL_HIGH: stat_out = 1'b1;
      SEL_LOW:  stat_out = 1'b0;
      SEL_HIZ:  stat_oe  = 1'b0;
      default:  stat_oe  = 1'b0;
    endcase
  end

endmodule

// File: rtl/pfd_lock_monitor.sv
module pfd_lock_monitor
  import lockmon_pkg::*;
#(
  parameter int ERR_W     = 8,
  parameter int RUN_LEN   = 40,
  parameter int SAMPLE_PS = 1000,
  parameter int WINDOW_PS = 3000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pfd_up,
  input  logic             pfd_dn,
  input  logic             ref_mark,
  input  logic [ERR_W-1:0] err_limit,
  input  logic [1:0]       stat_sel,
  output logic             lock,
  output logic             stat_out,
  output logic             stat_oe
);

  localparam int DEF_LIMIT = window_count(WINDOW_PS, SAMPLE_PS);

  logic             cycle_end;
  logic [ERR_W-1:0] cycle_err;
  stat_sel_e        sel_e;

  assign sel_e = stat_sel_e'(stat_sel);

  lockmon_err_meter #(.ERR_W(ERR_W)) u_meter (
    .clk       (clk),
    .rst       (rst),
    .pfd_up    (pfd_up),
    .pfd_dn    (pfd_dn),
    .ref_mark  (ref_mark),
    .cycle_end (cycle_end),
    .cycle_err (cycle_err)
  );

  lockmon_run_track #(
    .ERR_W     (ERR_W),
    .RUN_LEN   (RUN_LEN),
    .DEF_LIMIT (DEF_LIMIT)
  ) u_run (
    .clk       (clk),
    .rst       (rst),
    .cycle_end (cycle_end),
    .cycle_err (cycle_err),
    .err_limit (err_limit),
    .lock      (lock)
  );

  lockmon_status_mux u_mux (
    .lock     (lock),
    .sel      (sel_e),
    .stat_out (stat_out),
    .stat_oe  (stat_oe)
  );

  AST_LOCK_ONLY_AT_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(lock) |-> $past(cycle_end));                                    // R5
  AST_STAT_FOLLOWS_LOCK: assert property (@(posedge clk) disable iff (rst)
    (stat_sel == 2'b00) |-> (stat_oe && stat_out == lock));               // R9
  AST_HIZ_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (stat_sel == 2'b11) |-> (!stat_oe && !stat_out));                     // R9
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !lock);                                                       // R10

endmodule

// File: tb/pfd_lock_monitor_test.sv
`timescale 1ns/1ps
module pfd_lock_monitor_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pfd_up = 1'b0;
  logic       pfd_dn = 1'b0;
  logic       ref_mark = 1'b0;
  logic [7:0] err_limit = 8'd0;
  logic [1:0] stat_sel = 2'b00;
  logic       lock, stat_out, stat_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pfd_lock_monitor uut (
    .clk(clk), .rst(rst), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .ref_mark(ref_mark), .err_limit(err_limit), .stat_sel(stat_sel),
    .lock(lock), .stat_out(stat_out), .stat_oe(stat_oe)
  );

  // n cycles, error pulse length, how (bit0 up, bit1 dn), limit, expected lock
  typedef struct packed {
    int         n;
    int         err;
    logic [1:0] how;
    logic [7:0] lim;
    logic       exp;
  } vec_t;

  localparam vec_t VECS [0:9] = '{
    '{39, 2,  2'b01, 8'd0,  1'b0},  // R2 R5: 39 good, not yet locked
    '{1,  0,  2'b01, 8'd0,  1'b1},  // R5: 40th good cycle
    '{5,  2,  2'b10, 8'd0,  1'b1},  // R7: saturation holds lock
    '{1,  3,  2'b01, 8'd0,  1'b0},  // R4 R6: error equal to default limit
    '{39, 5,  2'b11, 8'd0,  1'b0},  // R1: overlap does not count
    '{1,  1,  2'b01, 8'd0,  1'b1},  // R1 R5
    '{1,  1,  2'b10, 8'd1,  1'b0},  // R4: programmed limit 1
    '{40, 0,  2'b01, 8'd1,  1'b1},  // R4 R5
    '{1,  9,  2'b01, 8'd10, 1'b1},  // R4: one below limit 10
    '{1,  10, 2'b10, 8'd10, 1'b0}   // R4 R6: at limit 10
  };

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one comparison cycle: error pulse, gap, marker; returns at the negedge
  // after the closing edge, when lock already reflects the cycle
  task automatic send_cycle(input int e, input logic [1:0] how);
    for (int i = 0; i < e; i++) begin
      @(negedge clk); pfd_up = how[0]; pfd_dn = how[1];
    end
    @(negedge clk); pfd_up = 1'b0; pfd_dn = 1'b0;
    @(negedge clk); ref_mark = 1'b1;
    @(negedge clk); ref_mark = 1'b0;
  endtask

  task automatic send_good(input int n);
    for (int i = 0; i < n; i++) send_cycle(0, 2'b01);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(lock, 1'b0, "R10 lock during reset");
    rst = 1'b0;
    @(negedge clk);
    check(lock, 1'b0, "R10 lock after reset");
    check(stat_out, 1'b0, "R9 sel00 out after reset");
    check(stat_oe, 1'b1, "R9 sel00 oe after reset");

    // R3: first marker only arms
    send_good(40);
    check(lock, 1'b0, "R3 40 edges after reset");
    send_good(1);
    check(lock, 1'b1, "R3 R5 41st edge");
    send_cycle(4, 2'b01);
    check(lock, 1'b0, "R6 error 4 drops lock");

    for (int v = 0; v < 10; v++) begin
      err_limit = VECS[v].lim;
      for (int k = 0; k < VECS[v].n; k++) send_cycle(VECS[v].err, VECS[v].how);
      check(lock, VECS[v].exp, $sformatf("vector %0d R1 R2 R4 R5 R6 R7", v));
    end

    // R8: long pulse must not wrap below the limit
    err_limit = 8'd255;
    send_good(40);
    check(lock, 1'b1, "R8 lock before long pulse");
    send_cycle(300, 2'b01);
    check(lock, 1'b0, "R8 300-period error with limit 255");

    // R9: status mux with lock low
    stat_sel = 2'b01; @(negedge clk);
    check(stat_out, 1'b1, "R9 sel01 out");
    check(stat_oe, 1'b1, "R9 sel01 oe");
    stat_sel = 2'b10; @(negedge clk);
    check(stat_out, 1'b0, "R9 sel10 out");
    check(stat_oe, 1'b1, "R9 sel10 oe");
    stat_sel = 2'b11; @(negedge clk);
    check(stat_oe, 1'b0, "R9 sel11 oe");
    check(stat_out, 1'b0, "R9 sel11 out");
    stat_sel = 2'b00; @(negedge clk);
    check(stat_out, 1'b0, "R9 sel00 lock low");
    err_limit = 8'd0;
    send_good(40);
    check(stat_out, 1'b1, "R9 sel00 lock high");
    check(lock, 1'b1, "R9 lock high");

    // R10: reset in the middle of lock
    rst = 1'b1;
    @(negedge clk);
    check(lock, 1'b0, "R10 reset drops lock");
    rst = 1'b0;
    send_good(40);
    check(lock, 1'b0, "R10 R3 run cleared by reset");
    send_good(1);
    check(lock, 1'b1, "R10 R5 relock");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule